// File: doc/BRIEF.md
# Single-Cycle R-Type Datapath

This block is a small processor core that finishes one instruction per clock. Each cycle it reads a 32-bit word from its own instruction store at the current program counter and splits it into register-format fields. For the three supported operations it reads two source registers, passes them through an ALU and writes the result to the destination register before the next instruction is fetched. The program counter then moves on by one word.

The instruction store and the register file are filled through a simple load port while the core is stopped. This is how a program and its starting register values are put in place. A run enable starts and stops execution. For each cycle the core shows its program counter, the instruction it is executing and a write-back trace: a valid flag, the destination index and the result. The trace for an instruction is valid during the cycle in which that instruction executes, and the register write takes effect at the rising edge that ends that cycle. A register-file read therefore sees the results of all earlier instructions.

Top module: `rtype_core`

## Requirements
- R1: After reset the PC reads 0. While `run_en` is low, `wb_valid` stays low.
- R2: While `run_en` is high the PC grows by 4 at every rising edge. While `run_en` is low it holds its value.
- R3: Instruction fields, MSB to LSB: op [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], func [5:0]. `wb_rd` carries the rd field.
- R4: When op = 0 and func = 0x21, the core writes R[rs] + R[rt], wrapped modulo 2^32, to R[rd].
- R5: When op = 0 and func = 0x23, the core writes R[rs] - R[rt], wrapped modulo 2^32, to R[rd].
- R6: When op = 0 and func = 0x25, the core writes R[rs] | R[rt] to R[rd].
- R7: Any other op or func value is a no-op. `wb_valid` stays low and no register changes. The all-zero word is one such no-op.
- R8: Register 0 always reads 0. A write to it, whether from an instruction or from the load port, has no effect.
- R9: A result written by one instruction can be used as a source by the very next instruction.
- R10: A load-port write with `load_rf` = 0 places `load_data` at word address `load_addr` of the instruction store, which is fetched when the PC equals 4 × `load_addr`. With `load_rf` = 1 it writes register `load_addr[4:0]`.
- R11: The shamt field has no effect on the three operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Executes one instruction per cycle when high |
| load_en | input | 1 | Load-port write strobe |
| load_rf | input | 1 | Load target: 1 register file, 0 instruction store |
| load_addr | input | 6 | Word address or register index of the load |
| load_data | input | 32 | Load data |
| pc | output | 32 | Current program counter |
| wb_valid | output | 1 | The current instruction writes a register at the next edge |
| wb_rd | output | 5 | Destination register of the current instruction |
| wb_data | output | 32 | ALU result of the current instruction |
| tr_instr | output | 32 | Instruction word being executed |

## Verification
The bench aims at arithmetic that wraps: a subtraction with a larger subtrahend and an addition that carries out of bit 31. A core that saturates or traps would show the wrong result there. It feeds one instruction's result straight into the next, which exposes a write that lands a cycle late. It also hits register 0 from both the load port and an instruction, then reads it back as a source, so a core that stores into register 0 would show the stray value. Words with a foreign opcode, a foreign function code or all zeros are mixed in. A decoder that looks at only one field, or that treats the zero word as an operation, would raise `wb_valid` or corrupt a register that a later instruction reads.

// File: rtl/rtype_pkg.sv
package rtype_pkg;

  // Register-format instruction word; field order is decoded, so it is fixed.
  typedef struct packed {
    logic [5:0] op;
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] rd;
    logic [4:0] shamt;
    logic [5:0] fn;
  } instr_t;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_sel_e;

  localparam logic [5:0] OPC_REG = 6'h00;
  localparam logic [5:0] FN_ADD  = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h23;
  localparam logic [5:0] FN_OR   = 6'h25;

endpackage

// File: rtl/rtype_decode.sv
module rtype_decode
  import rtype_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] fn,
  output logic       legal,
  output alu_sel_e   sel
);

  always_comb begin
    legal = 1'b0;
    sel   = ALU_ADD;
    if (op == OPC_REG) begin
      case (fn)
        FN_ADD: begin legal = 1'b1; sel = ALU_ADD; end
        FN_SUB: begin legal = 1'b1; sel = ALU_SUB; end
        FN_OR:  begin legal = 1'b1; sel = ALU_OR;  end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rtype_alu.sv
module rtype_alu
  import rtype_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_sel_e     sel,
  output logic [W-1:0] y
);

  logic [W-1:0] sum_w, dif_w, or_w;

  // All results formed in parallel; the select only steers the output mux.
  always_comb begin
    sum_w = a + b;
    dif_w = a - b;
    or_w  = a | b;
    case (sel)
      ALU_ADD: y = sum_w;
      ALU_SUB: y = dif_w;
      ALU_OR:  y = or_w;
      default: y = or_w;
    endcase
  end

endmodule

// File: rtl/rtype_regfile.sv
module rtype_regfile #(
  parameter int unsigned W     = 32,
  parameter int unsigned NREGS = 32,
  parameter int unsigned NRD   = 2
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREGS)-1:0] waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][$clog2(NREGS)-1:0] raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);

  localparam int unsigned AW = $clog2(NREGS);

  // Entry 0 has no storage: it reads as zero and swallows writes.
  logic [W-1:0] mem_q [1:NREGS-1];

  always_ff @(posedge clk) begin
    for (int i = 1; i < NREGS; i++) begin
      if (we && (waddr == AW'(i))) begin
        mem_q[i] <= wdata;
      end
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (raddr[g] == '0) ? '0 : mem_q[raddr[g]];
  end

endmodule

// File: rtl/rtype_fetch.sv
module rtype_fetch
  import rtype_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned PC_STEP    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step_en,
  input  logic                          ld_we,
  input  logic [$clog2(IMEM_WORDS)-1:0] ld_addr,
  input  logic [31:0]                   ld_data,
  output logic [W-1:0]                  pc,
  output instr_t                        instr
);

  localparam int unsigned IAW = $clog2(IMEM_WORDS);

  logic [31:0]  imem_q [IMEM_WORDS];
  logic [W-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q + W'(PC_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (step_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_we) begin
      imem_q[ld_addr] <= ld_data;
    end
  end

  assign pc    = pc_q;
  assign instr = imem_q[pc_q[IAW+1:2]];

endmodule

// File: rtl/rtype_core.sv
module rtype_core
  import rtype_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter int unsigned NREGS      = 32,
  parameter int unsigned IMEM_WORDS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run_en,
  input  logic                          load_en,
  input  logic                          load_rf,
  input  logic [$clog2(IMEM_WORDS)-1:0] load_addr,
  input  logic [W-1:0]                  load_data,
  output logic [W-1:0]                  pc,
  output logic                          wb_valid,
  output logic [$clog2(NREGS)-1:0]      wb_rd,
  output logic [W-1:0]                  wb_data,
  output logic [31:0]                   tr_instr
);

  localparam int unsigned RAW = $clog2(NREGS);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic          step_en;
  instr_t        instr;
  logic          legal;
  alu_sel_e      sel;
  logic [1:0][RAW-1:0] rf_raddr;
  logic [1:0][W-1:0]   rf_rdata;
  logic [W-1:0]  rs_val, rt_val, alu_y;
  logic          ld_rf_we, ld_im_we;
  logic          rf_we;
  logic [RAW-1:0] rf_waddr;
  logic [W-1:0]  rf_wdata;

  assign step_en  = run_en & rst_sync_n;
  assign ld_rf_we = load_en & load_rf;
  assign ld_im_we = load_en & ~load_rf;

  rtype_fetch #(
    .W          (W),
    .IMEM_WORDS (IMEM_WORDS),
    .PC_STEP    (4)
  ) i_fetch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step_en (step_en),
    .ld_we   (ld_im_we),
    .ld_addr (load_addr),
    .ld_data (load_data[31:0]),
    .pc      (pc),
    .instr   (instr)
  );

  rtype_decode i_decode (
    .op    (instr.op),
    .fn    (instr.fn),
    .legal (legal),
    .sel   (sel)
  );

  assign rf_raddr = {instr.rt, instr.rs};
  assign rs_val   = rf_rdata[0];
  assign rt_val   = rf_rdata[1];

  // Write port: the load port has priority; it is only used while stopped.
  always_comb begin
    rf_we    = ld_rf_we | (step_en & legal);
    rf_waddr = ld_rf_we ? load_addr[RAW-1:0] : instr.rd;
    rf_wdata = ld_rf_we ? load_data : alu_y;
  end

  rtype_regfile #(
    .W     (W),
    .NREGS (NREGS),
    .NRD   (2)
  ) i_regfile (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  rtype_alu #(
    .W (W)
  ) i_alu (
    .a   (rs_val),
    .b   (rt_val),
    .sel (sel),
    .y   (alu_y)
  );

  assign wb_valid = step_en & legal;
  assign wb_rd    = instr.rd;
  assign wb_data  = alu_y;
  assign tr_instr = instr;

endmodule

// File: rtl/rtype_core_chk.sv
module rtype_core_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         run_en,
  input logic [W-1:0] pc,
  input logic         wb_valid,
  input logic [4:0]   wb_rd,
  input logic [W-1:0] wb_data,
  input logic [31:0]  tr_instr,
  input logic [W-1:0] rs_val,
  input logic [W-1:0] rt_val
);

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run_en |=> (pc == $past(pc) + W'(4)));  // R2

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run_en |=> $stable(pc));  // R2

  AST_IDLE_TRACE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run_en |-> !wb_valid);  // R1

  AST_RD_FIELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_valid |-> (wb_rd == tr_instr[15:11]));  // R3

  AST_ONLY_KNOWN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_valid |-> (tr_instr[31:26] == 6'h00 &&
                  (tr_instr[5:0] == 6'h21 || tr_instr[5:0] == 6'h23 || tr_instr[5:0] == 6'h25)));  // R7

  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wb_valid && tr_instr[5:0] == 6'h21) |-> (wb_data == rs_val + rt_val));  // R4

  AST_SUB_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wb_valid && tr_instr[5:0] == 6'h23) |-> (wb_data == rs_val - rt_val));  // R5

  AST_OR_BITS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wb_valid && tr_instr[5:0] == 6'h25) |-> (wb_data == (rs_val | rt_val)));  // R6

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_en && tr_instr[25:21] == 5'd0) |-> (rs_val == '0));  // R8

endmodule

bind rtype_core rtype_core_chk #(.W(W)) i_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .run_en     (run_en),
  .pc         (pc),
  .wb_valid   (wb_valid),
  .wb_rd      (wb_rd),
  .wb_data    (wb_data),
  .tr_instr   (tr_instr),
  .rs_val     (rs_val),
  .rt_val     (rt_val)
);

// File: tb/test_rtype_core.sv
module test_rtype_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_en;
  logic        load_en;
  logic        load_rf;
  logic [5:0]  load_addr;
  logic [31:0] load_data;
  logic [31:0] pc;
  logic        wb_valid;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data;
  logic [31:0] tr_instr;

  always #5 clk = ~clk;  // 100 MHz

  rtype_core i_rtype_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .load_en   (load_en),
    .load_rf   (load_rf),
    .load_addr (load_addr),
    .load_data (load_data),
    .pc        (pc),
    .wb_valid  (wb_valid),
    .wb_rd     (wb_rd),
    .wb_data   (wb_data),
    .tr_instr  (tr_instr)
  );

  typedef struct {
    logic [31:0] pc;
    bit          valid;
    logic [4:0]  rd;
    logic [31:0] data;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] mrf [32];
  int          errors = 0;
  int          checks = 0;
  bit          mon_on = 1'b0;
  bit          done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rword(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [4:0] sh, input logic [5:0] fn);
    return {op, rs, rt, rd, sh, fn};
  endfunction

  task automatic load(input bit to_rf, input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    load_en = 1'b1; load_rf = to_rf; load_addr = a; load_data = d;
    @(posedge clk); #1;
    load_en = 1'b0;
  endtask

  task automatic set_reg(input logic [4:0] r, input logic [31:0] v);
    load(1'b1, {1'b0, r}, v);
    if (r != 5'd0) mrf[r] = v;  // R8: register 0 keeps reading zero
  endtask

  // Driver: places instruction k at word k (R10) and predicts its trace.
  task automatic issue(input int k, input logic [31:0] w, input string req);
    exp_t e;
    logic [5:0]  op = w[31:26];
    logic [4:0]  rs = w[25:21];
    logic [4:0]  rt = w[20:16];
    logic [4:0]  rd = w[15:11];
    logic [5:0]  fn = w[5:0];
    logic [31:0] a  = (rs == 5'd0) ? 32'd0 : mrf[rs];
    logic [31:0] b  = (rt == 5'd0) ? 32'd0 : mrf[rt];
    load(1'b0, 6'(k), w);
    e.pc    = 32'(k * 4);
    e.valid = (op == 6'h00) && (fn == 6'h21 || fn == 6'h23 || fn == 6'h25);
    e.rd    = rd;
    e.data  = (fn == 6'h21) ? a + b : (fn == 6'h23) ? a - b : (a | b);
    e.req   = req;
    sb_q.push_back(e);
    if (e.valid && rd != 5'd0) mrf[rd] = e.data;
  endtask

  // Monitor: one expected item per executed cycle.
  always @(negedge clk) begin
    if (mon_on && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(pc == e.pc, "R2 pc", pc, e.pc);
      chk(wb_valid == e.valid, {e.req, " wb_valid"}, 32'(wb_valid), 32'(e.valid));
      if (e.valid) begin
        chk(wb_rd == e.rd, "R3 rd field", 32'(wb_rd), 32'(e.rd));
        chk(wb_data == e.data, e.req, wb_data, e.data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; load_en = 1'b0; load_rf = 1'b0;
    load_addr = '0; load_data = '0;
    for (int i = 0; i < 32; i++) mrf[i] = 32'd0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pc == 32'd0, "R1 reset pc", pc, 32'd0);
    chk(wb_valid == 1'b0, "R1 idle trace", 32'(wb_valid), 32'd0);

    for (int i = 0; i < 64; i++) load(1'b0, 6'(i), 32'd0);

    set_reg(5'd1,  32'h0000_0005);
    set_reg(5'd2,  32'h0000_0007);
    set_reg(5'd9,  32'hFFFF_FFFF);
    set_reg(5'd10, 32'h0000_0002);
    set_reg(5'd11, 32'hF0F0_0000);
    set_reg(5'd12, 32'h0000_0F0F);
    set_reg(5'd13, 32'h1234_5678);
    set_reg(5'd14, 32'h0000_00AA);
    set_reg(5'd0,  32'hDEAD_BEEF);  // R8: load to register 0 ignored

    issue(0,  rword(6'h00, 5'd1,  5'd2,  5'd3,  5'd0,  6'h21), "R4 add");
    issue(1,  rword(6'h00, 5'd1,  5'd2,  5'd4,  5'd0,  6'h23), "R5 sub wraps");
    issue(2,  rword(6'h00, 5'd11, 5'd12, 5'd5,  5'd0,  6'h25), "R6 or");
    issue(3,  rword(6'h00, 5'd9,  5'd10, 5'd6,  5'd0,  6'h21), "R4 add wraps");
    issue(4,  rword(6'h00, 5'd6,  5'd6,  5'd7,  5'd0,  6'h21), "R9 back-to-back");
    issue(5,  rword(6'h01, 5'd1,  5'd2,  5'd14, 5'd0,  6'h21), "R7 foreign op");
    issue(6,  rword(6'h00, 5'd1,  5'd2,  5'd14, 5'd0,  6'h20), "R7 foreign func");
    issue(7,  rword(6'h00, 5'd1,  5'd2,  5'd0,  5'd0,  6'h21), "R8 write r0");
    issue(8,  rword(6'h00, 5'd0,  5'd13, 5'd15, 5'd0,  6'h25), "R8 r0 reads zero");
    issue(9,  rword(6'h00, 5'd1,  5'd2,  5'd16, 5'd31, 6'h21), "R11 shamt ignored");
    issue(10, rword(6'h00, 5'd14, 5'd0,  5'd17, 5'd0,  6'h25), "R7 r14 untouched");
    issue(11, rword(6'h00, 5'd0,  5'd0,  5'd18, 5'd0,  6'h23), "R8 r0 after writes");
    issue(12, rword(6'h00, 5'd4,  5'd3,  5'd19, 5'd7,  6'h23), "R5 sub of results");

    @(posedge clk); #1;
    run_en = 1'b1;
    mon_on = 1'b1;
    wait (sb_q.size() == 0);
    @(posedge clk); #1;
    run_en = 1'b0;
    mon_on = 1'b0;

    repeat (3) begin
      @(negedge clk);
      chk(pc == 32'd52, "R2 pc holds", pc, 32'd52);
      chk(wb_valid == 1'b0, "R1 idle trace", 32'(wb_valid), 32'd0);
    end

    // Zero words past the program: no-ops while the PC keeps stepping.
    @(posedge clk); #1;
    run_en = 1'b1;
    @(negedge clk);
    chk(pc == 32'd52, "R2 restart", pc, 32'd52);
    chk(wb_valid == 1'b0, "R7 zero word", 32'(wb_valid), 32'd0);
    @(negedge clk);
    chk(pc == 32'd56, "R2 step", pc, 32'd56);
    chk(wb_valid == 1'b0, "R7 zero word", 32'(wb_valid), 32'd0);
    @(posedge clk); #1;
    run_en = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule